// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It runs two predictors side by side and uses a third table to choose between them. The local predictor keeps a short outcome history for each branch, selected by the branch address. That history then selects a 3-bit saturating counter. The global predictor uses a register of the most recent outcomes of all branches to select a 2-bit counter. The same register also selects a 2-bit choice counter, which decides which of the two component predictions is used.

On the predict side, the fetch stage presents a PC. In the same cycle, without a clock edge, the block returns the final direction, both component directions, and the three table indices it used. The pipeline carries these values with the branch. When the branch resolves, the pipeline returns them on the update side together with the real outcome. All tables are then trained at the captured indices. Target prediction and history repair after a flush are left to other blocks.

Top module: `tourney_predictor`

## Requirements
- R1: After reset all local histories and the global history are zero. Every 3-bit local counter holds 3, and every 2-bit global counter and choice counter holds 1. So the first prediction for any PC is not-taken from both components, and the choice selects the local one.
- R2: The local history entry is selected by PC bits [11:2], and this index is output on `pred_lht_idx`. The 10-bit history stored there is output on `pred_lhist` and selects the local counter.
- R3: A local counter predicts taken when its value is 4 or more. It goes up on a taken outcome and down on a not-taken outcome, and it stays at 7 and at 0 rather than wrapping.
- R4: A global counter is selected by the 12-bit global history, which is output on `pred_ghist`. It predicts taken when its value is 2 or more, and it saturates at 0 and 3.
- R5: The choice counter, selected by the same global history, makes `pred_taken` equal the global prediction when its value is 2 or more and the local prediction otherwise.
- R6: A choice counter changes only on an update whose two captured component predictions differ. It goes up (saturating at 3) when the global one matched the outcome, and down (saturating at 0) when the local one did.
- R7: Every update shifts the outcome (1 = taken) into bit 0 of the global history and into bit 0 of the local history entry at `upd_lht_idx`. The oldest bit is dropped.
- R8: An update trains the local counter at `upd_lhist` and the global and choice counters at `upd_ghist`, whatever PC is presented at the same time.
- R9: A prediction reflects the table state before any update applied on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | 32 | PC of the branch being predicted |
| pred_taken | output | 1 | Final predicted direction |
| pred_local_taken | output | 1 | Local component prediction |
| pred_global_taken | output | 1 | Global component prediction |
| pred_lht_idx | output | 10 | Local history table index used |
| pred_lhist | output | 10 | Local history value (local counter index) |
| pred_ghist | output | 12 | Global history value (global and choice index) |
| upd_valid | input | 1 | Resolved branch update strobe |
| upd_taken | input | 1 | Resolved outcome |
| upd_lht_idx | input | 10 | Captured local history table index |
| upd_lhist | input | 10 | Captured local history value |
| upd_ghist | input | 12 | Captured global history value |
| upd_local_taken | input | 1 | Captured local component prediction |
| upd_global_taken | input | 1 | Captured global component prediction |

## Verification
The bench drives one branch that is always taken and then one that is never taken. These long runs push a local counter to 7 and to 0, and a global counter to 3 and to 0. A counter that wraps instead of saturating would flip the next prediction the wrong way. Mixed patterns from several branches make the two components disagree, so the choice counter has to train in the right direction. They also make the components agree, so it has to hold. A choice that trains on agreement, or steps the wrong way, shows up as a wrong final direction. A further test updates with indices captured in an earlier cycle while a different PC is presented, and then resets after training. These catch a design that trains at the live indices, or that leaves trained counters in place after reset.

// File: rtl/tp_pkg.sv
package tp_pkg;
   // Direction a counter moves on update
   typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} ctr_dir_e;

   function automatic ctr_dir_e outcome_dir(input logic taken);
      return taken ? DIR_UP : DIR_DOWN;
   endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
   parameter int CW    = 2,
   parameter int IDX_W = 12,
   parameter int INIT  = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [CW-1:0]       rd_val,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  tp_pkg::ctr_dir_e    wr_dir
);
   localparam int DEPTH = 1 << IDX_W;
   localparam logic [CW-1:0] MAXV = '1;
   localparam logic [CW-1:0] INITV = CW'(INIT);

   generate
      if (CW < 1) begin : g_bad_cw
         $error("tp_ctr_table: counter width must be at least 1");
      end
      if (INIT > (1 << CW) - 1) begin : g_bad_init
         $error("tp_ctr_table: reset value does not fit the counter");
      end
   endgenerate

   logic [CW-1:0] mem [DEPTH];

   assign rd_val = mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= INITV;
      end else if (wr_en) begin
         if (wr_dir == tp_pkg::DIR_UP) begin
            if (mem[wr_idx] != MAXV) mem[wr_idx] <= mem[wr_idx] + 1'b1;
         end else begin
            if (mem[wr_idx] != '0) mem[wr_idx] <= mem[wr_idx] - 1'b1;
         end
      end
   end

   // R3 / R4: counters saturate at both ends
   assert_sat_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_dir == tp_pkg::DIR_UP && mem[wr_idx] == MAXV)
      |=> (mem[$past(wr_idx)] == MAXV));
   assert_sat_bottom_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_dir == tp_pkg::DIR_DOWN && mem[wr_idx] == '0)
      |=> (mem[$past(wr_idx)] == '0));
   // R3: an up step never lowers the counter
   assert_up_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_dir == tp_pkg::DIR_UP)
      |=> (mem[$past(wr_idx)] >= $past(mem[wr_idx])));
   // R6: without a write enable the entry being read is left alone
   assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en) |=> (mem[$past(rd_idx)] == $past(mem[rd_idx])));
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
   parameter int IDX_W = 10,
   parameter int HW    = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [HW-1:0]    rd_hist,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_bit
);
   localparam int DEPTH = 1 << IDX_W;

   generate
      if (HW < 2) begin : g_bad_hw
         $error("tp_hist_table: history must be at least 2 bits");
      end
   endgenerate

   logic [HW-1:0] mem [DEPTH];

   assign rd_hist = mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_idx] <= {mem[wr_idx][HW-2:0], wr_bit};
      end
   end

   // R7: newest outcome lands in bit 0, older bits move up
   assert_local_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mem[$past(wr_idx)] == {$past(mem[wr_idx][HW-2:0]), $past(wr_bit)}));
endmodule

// File: rtl/tp_ghr.sv
module tp_ghr #(
   parameter int HW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_en,
   input  logic          shift_bit,
   output logic [HW-1:0] hist
);
   generate
      if (HW < 2) begin : g_bad_hw
         $error("tp_ghr: history must be at least 2 bits");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hist <= '0;
      else if (shift_en) hist <= {hist[HW-2:0], shift_bit};
   end

   // R7: global history shift
   assert_global_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (hist == {$past(hist[HW-2:0]), $past(shift_bit)}));
   assert_global_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(hist));
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor #(
   parameter int PC_W      = 32,
   parameter int PC_LSB    = 2,
   parameter int LHT_IDX_W = 10,
   parameter int LHIST_W   = 10,
   parameter int LCTR_W    = 3,
   parameter int GHIST_W   = 12,
   parameter int GCTR_W    = 2,
   parameter int CCTR_W    = 2,
   parameter int LCTR_INIT = 3,
   parameter int GCTR_INIT = 1,
   parameter int CCTR_INIT = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PC_W-1:0]      pred_pc,
   output logic                 pred_taken,
   output logic                 pred_local_taken,
   output logic                 pred_global_taken,
   output logic [LHT_IDX_W-1:0] pred_lht_idx,
   output logic [LHIST_W-1:0]   pred_lhist,
   output logic [GHIST_W-1:0]   pred_ghist,
   input  logic                 upd_valid,
   input  logic                 upd_taken,
   input  logic [LHT_IDX_W-1:0] upd_lht_idx,
   input  logic [LHIST_W-1:0]   upd_lhist,
   input  logic [GHIST_W-1:0]   upd_ghist,
   input  logic                 upd_local_taken,
   input  logic                 upd_global_taken
);
   import tp_pkg::*;

   generate
      if (PC_LSB + LHT_IDX_W > PC_W) begin : g_bad_pc
         $error("tourney_predictor: local index field exceeds PC width");
      end
   endgenerate

   logic [LCTR_W-1:0] lctr_val;
   logic [GCTR_W-1:0] gctr_val;
   logic [CCTR_W-1:0] cctr_val;
   logic              choose_global;
   logic              disagree;

   // R2: local history index from the PC
   assign pred_lht_idx = pred_pc[PC_LSB +: LHT_IDX_W];

   tp_hist_table #(.IDX_W(LHT_IDX_W), .HW(LHIST_W)) u_lht (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (pred_lht_idx),
      .rd_hist (pred_lhist),
      .wr_en   (upd_valid),
      .wr_idx  (upd_lht_idx),
      .wr_bit  (upd_taken)
   );

   tp_ghr #(.HW(GHIST_W)) u_ghr (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (upd_valid),
      .shift_bit (upd_taken),
      .hist      (pred_ghist)
   );

   tp_ctr_table #(.CW(LCTR_W), .IDX_W(LHIST_W), .INIT(LCTR_INIT)) u_lpt (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (pred_lhist),
      .rd_val (lctr_val),
      .wr_en  (upd_valid),
      .wr_idx (upd_lhist),
      .wr_dir (outcome_dir(upd_taken))
   );

   tp_ctr_table #(.CW(GCTR_W), .IDX_W(GHIST_W), .INIT(GCTR_INIT)) u_gpt (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (pred_ghist),
      .rd_val (gctr_val),
      .wr_en  (upd_valid),
      .wr_idx (upd_ghist),
      .wr_dir (outcome_dir(upd_taken))
   );

   // R6: choice trains only on disagreement, toward the component that was right
   assign disagree = upd_valid && (upd_local_taken != upd_global_taken);

   tp_ctr_table #(.CW(CCTR_W), .IDX_W(GHIST_W), .INIT(CCTR_INIT)) u_cpt (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (pred_ghist),
      .rd_val (cctr_val),
      .wr_en  (disagree),
      .wr_idx (upd_ghist),
      .wr_dir (outcome_dir(upd_global_taken == upd_taken))
   );

   // Upper half of each counter range means taken / use global
   assign pred_local_taken  = lctr_val[LCTR_W-1];
   assign pred_global_taken = gctr_val[GCTR_W-1];
   assign choose_global     = cctr_val[CCTR_W-1];
   assign pred_taken        = choose_global ? pred_global_taken : pred_local_taken;

   // R5: when components agree the final prediction follows them
   assert_agree_final_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_local_taken == pred_global_taken) |-> (pred_taken == pred_local_taken));
endmodule

// File: tb/tb_tourney_predictor.sv
module tb_tourney_predictor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pred_pc = '0;
   logic        pred_taken, pred_local_taken, pred_global_taken;
   logic [9:0]  pred_lht_idx, pred_lhist;
   logic [11:0] pred_ghist;
   logic        upd_valid = 1'b0, upd_taken = 1'b0;
   logic [9:0]  upd_lht_idx = '0, upd_lhist = '0;
   logic [11:0] upd_ghist = '0;
   logic        upd_local_taken = 1'b0, upd_global_taken = 1'b0;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   tourney_predictor dut (
      .clk (clk), .rst_n (rst_n), .pred_pc (pred_pc),
      .pred_taken (pred_taken), .pred_local_taken (pred_local_taken),
      .pred_global_taken (pred_global_taken), .pred_lht_idx (pred_lht_idx),
      .pred_lhist (pred_lhist), .pred_ghist (pred_ghist),
      .upd_valid (upd_valid), .upd_taken (upd_taken), .upd_lht_idx (upd_lht_idx),
      .upd_lhist (upd_lhist), .upd_ghist (upd_ghist),
      .upd_local_taken (upd_local_taken), .upd_global_taken (upd_global_taken)
   );

   // Reference state built from the requirements
   logic [9:0]  m_lht [1024];
   int          m_lpt [1024];
   int          m_gpt [4096];
   int          m_cpt [4096];
   logic [11:0] m_ghr;

   // Values the model predicted last cycle (the "captured" set)
   logic [9:0]  e_lidx, e_lh;
   logic [11:0] e_gh;
   logic        e_lp, e_gp, e_fin;

   // Stimulus table: {pc, outcome}
   localparam int NV = 16;
   localparam logic [32:0] VEC [NV] = '{
      {32'h0000_1000, 1'b1}, {32'h0000_2004, 1'b0}, {32'h0000_1000, 1'b1}, {32'h0000_300C, 1'b1},
      {32'h0000_2004, 1'b1}, {32'h0000_1000, 1'b0}, {32'h0000_300C, 1'b0}, {32'h0000_2004, 1'b0},
      {32'h0000_1000, 1'b1}, {32'h0000_4010, 1'b1}, {32'h0000_4010, 1'b0}, {32'h0000_300C, 1'b1},
      {32'h0000_2004, 1'b1}, {32'h0000_1000, 1'b1}, {32'h0000_4010, 1'b1}, {32'h0000_300C, 1'b0}
   };

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 1024; i++) begin m_lht[i] = '0; m_lpt[i] = 3; end
      for (int i = 0; i < 4096; i++) begin m_gpt[i] = 1; m_cpt[i] = 1; end
      m_ghr = '0;
   endtask

   task automatic model_predict(input logic [31:0] pc);
      e_lidx = pc[11:2];
      e_lh   = m_lht[e_lidx];
      e_gh   = m_ghr;
      e_lp   = (m_lpt[e_lh] >= 4);
      e_gp   = (m_gpt[e_gh] >= 2);
      e_fin  = (m_cpt[e_gh] >= 2) ? e_gp : e_lp;
   endtask

   task automatic model_update(input logic t, input logic [9:0] li, input logic [9:0] lh,
                               input logic [11:0] gh, input logic lp, input logic gp);
      if (t) begin
         if (m_lpt[lh] < 7) m_lpt[lh]++;
         if (m_gpt[gh] < 3) m_gpt[gh]++;
      end else begin
         if (m_lpt[lh] > 0) m_lpt[lh]--;
         if (m_gpt[gh] > 0) m_gpt[gh]--;
      end
      if (lp != gp) begin
         if (gp == t) begin if (m_cpt[gh] < 3) m_cpt[gh]++; end
         else         begin if (m_cpt[gh] > 0) m_cpt[gh]--; end
      end
      m_lht[li] = {m_lht[li][8:0], t};
      m_ghr     = {m_ghr[10:0], t};
   endtask

   task automatic check_pred(input string tag);
      chk({"R2 ", tag}, "lht_idx", 32'(pred_lht_idx), 32'(e_lidx));
      chk({"R2 ", tag}, "lhist",   32'(pred_lhist),   32'(e_lh));
      chk({"R4 ", tag}, "ghist",   32'(pred_ghist),   32'(e_gh));
      chk({"R3 ", tag}, "local",   32'(pred_local_taken),  32'(e_lp));
      chk({"R4 ", tag}, "global",  32'(pred_global_taken), 32'(e_gp));
      chk({"R5 R6 ", tag}, "final", 32'(pred_taken), 32'(e_fin));
   endtask

   // One cycle: present pc, check prediction (state before edge, R9), update with it
   task automatic step(input logic [31:0] pc, input logic t, input string tag);
      @(negedge clk);
      pred_pc = pc;
      model_predict(pc);
      upd_valid = 1'b1; upd_taken = t;
      upd_lht_idx = e_lidx; upd_lhist = e_lh; upd_ghist = e_gh;
      upd_local_taken = e_lp; upd_global_taken = e_gp;
      #1;
      check_pred(tag);
      @(posedge clk);
      model_update(t, e_lidx, e_lh, e_gh, e_lp, e_gp);
      #1 upd_valid = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      upd_valid = 1'b0;
      model_reset();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      #2_000_000;
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [9:0]  c_li, c_lh;
      logic [11:0] c_gh;
      logic        c_lp, c_gp;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      pred_pc = 32'h0000_1ABC;
      #1;
      chk("R1", "final",  32'(pred_taken), 32'h0);
      chk("R1", "local",  32'(pred_local_taken), 32'h0);
      chk("R1", "global", 32'(pred_global_taken), 32'h0);
      chk("R1", "ghist",  32'(pred_ghist), 32'h0);
      chk("R1", "lhist",  32'(pred_lhist), 32'h0);
      chk("R2", "lht_idx PC[11:2]", 32'(pred_lht_idx), 32'h2AF);

      // Vector table walked several times (R2..R7, R9)
      for (int pass = 0; pass < 10; pass++)
         for (int v = 0; v < NV; v++)
            step(VEC[v][32:1], VEC[v][0], "vector");

      // R3 R4: always-taken branch saturates local at 7 and global at 3
      do_reset();
      for (int i = 0; i < 30; i++) step(32'h0000_0A40, 1'b1, "sat-high");
      step(32'h0000_0A40, 1'b0, "sat-high exit R3");
      step(32'h0000_0A40, 1'b1, "sat-high reentry R4");
      // R3 R4: never-taken branch saturates at 0
      do_reset();
      for (int i = 0; i < 30; i++) step(32'h0000_0B80, 1'b0, "sat-low");
      step(32'h0000_0B80, 1'b1, "sat-low flip R3");
      for (int i = 0; i < 12; i++) step(32'h0000_0B80, 1'b0, "sat-low again R4");

      // R7: global history collects outcomes from different branches in order
      do_reset();
      step(32'h0000_0100, 1'b1, "ghr R7");
      step(32'h0000_0200, 1'b0, "ghr R7");
      step(32'h0000_0300, 1'b1, "ghr R7");
      @(negedge clk);
      #1 chk("R7", "ghist 101", 32'(pred_ghist), 32'h5);
      pred_pc = 32'h0000_0100;
      #1 chk("R7", "local hist of 0x100", 32'(pred_lhist), 32'h1);

      // R8: update uses indices captured earlier while a different PC is shown
      @(negedge clk);
      pred_pc = 32'h0000_0100;
      model_predict(32'h0000_0100);
      c_li = e_lidx; c_lh = e_lh; c_gh = e_gh; c_lp = e_lp; c_gp = e_gp;
      @(negedge clk);
      pred_pc = 32'h0000_0FFC;
      upd_valid = 1'b1; upd_taken = 1'b1;
      upd_lht_idx = c_li; upd_lhist = c_lh; upd_ghist = c_gh;
      upd_local_taken = c_lp; upd_global_taken = c_gp;
      @(posedge clk);
      model_update(1'b1, c_li, c_lh, c_gh, c_lp, c_gp);
      #1 upd_valid = 1'b0;
      @(negedge clk);
      pred_pc = 32'h0000_0FFC;
      model_predict(32'h0000_0FFC);
      #1 chk("R8", "untouched lhist of 0xFFC", 32'(pred_lhist), 32'(e_lh));
      pred_pc = 32'h0000_0100;
      model_predict(32'h0000_0100);
      #1 chk("R8", "lhist of captured 0x100", 32'(pred_lhist), 32'h3);
      for (int i = 0; i < 6; i++) step(32'h0000_0100, 1'b1, "captured R8");

      // R6: train local-favoring then global-favoring disagreements via table replay
      for (int pass = 0; pass < 4; pass++)
         for (int v = NV - 1; v >= 0; v--)
            step(VEC[v][32:1], ~VEC[v][0], "choice R6");

      // R1: reset clears trained state
      do_reset();
      pred_pc = 32'h0000_0100;
      #1;
      chk("R1", "post-train local", 32'(pred_local_taken), 32'h0);
      chk("R1", "post-train global", 32'(pred_global_taken), 32'h0);
      chk("R1", "post-train lhist", 32'(pred_lhist), 32'h0);
      chk("R1", "post-train ghist", 32'(pred_ghist), 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule